// File: doc/BRIEF.md
# Paired-Page Associative Translation Buffer

This block is a small, fully associative table of address translations. Each entry covers a pair of adjacent virtual pages with one tag. It holds two physical frame records: one for the even page of the pair and one for the odd page. A request carries a virtual page number and an address-space identifier. Every entry compares them in parallel, using its own page mask to exclude low tag bits from the compare, and its global flag to bypass the identifier check. The result comes back in the same cycle: a hit flag, the winning index, a probe code, and the full stored entry.

Software-style maintenance uses three paths. An indexed write replaces one entry on the next clock edge. A flush strobe clears the whole table. A read-back pointer selects one entry for inspection and steps forward only when asked.

The lookup port is a stream sink with a valid qualifier and no ready. It is always ready, so it never applies back-pressure. Its results are combinational and qualified by the same cycle's `lk_valid`. The write, flush and pointer pins are plain controls.

Top module: `paired_tlb`

## Requirements
- R1: An entry's tag compare covers only the bit positions where its mask bit is 0. Bits where the mask is 1 are ignored.
- R2: A hit also needs the entry's global flag to be 1, or its stored 8-bit identifier to equal `lk_asid`.
- R3: An entry takes part in matching only if at least one of its two valid bits is 1. A cleared or invalid entry never hits.
- R4: When several entries match, `hit_idx` is the lowest-numbered matching entry.
- R5: `probe_res` is `{1'b0, hit_idx}` on a hit. It is all ones when there is no hit.
- R6: On a hit, `hit_data` equals the stored entry word. The word is packed MSB first as tag[18:0], mask[18:0], asid[7:0], global, then the even record {frame[19:0], attr[2:0], dirty, valid}, then the odd record in the same form (97 bits). On a miss, `hit_data` is 0.
- R7: A write whose `wr_idx` is DEPTH or above changes no entry.
- R8: A write with `wr_idx` below DEPTH replaces that entry at the next rising clock edge.
- R9: `flush` clears every entry to zero and sets the pointer to 0 at the next edge. It takes precedence over a write and an advance in the same cycle.
- R10: `ptr_data` shows the entry selected by `ptr`. `ptr` increments by one, wrapping from DEPTH-1 to 0, only in cycles where `ptr_adv` is 1.
- R11: After reset, all entries are zero and `ptr` is 0.
- R12: While `lk_valid` is 0, `hit` is 0 and `probe_res` is all ones, whatever the other lookup inputs hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_valid | input | 1 | Lookup request qualifier |
| lk_vpn | input | 19 | Requested virtual page-pair number |
| lk_asid | input | 8 | Requested address-space identifier |
| hit | output | 1 | A valid request matched an entry |
| hit_idx | output | 4 | Index of the winning entry |
| probe_res | output | 5 | Probe code: index on hit, all ones on miss |
| hit_data | output | 97 | Winning entry word, zero on miss |
| wr_en | input | 1 | Indexed write strobe |
| wr_idx | input | 5 | Target index of the write |
| wr_data | input | 97 | Entry word to store |
| flush | input | 1 | Clear all entries and the pointer |
| ptr_adv | input | 1 | Step the read-back pointer |
| ptr | output | 4 | Read-back pointer |
| ptr_data | output | 97 | Entry selected by the pointer |

## Verification
The hardest case to reach from the ports is a tie between matching entries. Two entries must match the same request while the lower-numbered one is made to stop matching. The stimulus loads duplicate tags at indices 0 and 5 with the same identifier, then rewrites entry 0 with a different identifier. The same request must then move from index 0 to index 5.

Mask-covered bits are exercised by requests that differ from a masked entry's tag only inside the mask, and then just one bit above it. The table also holds an entry that carries a tag but has both valid bits clear. It shows that stored-but-invalid entries stay invisible.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  localparam int VPN_W  = 19;
  localparam int PFN_W  = 20;
  localparam int ASID_W = 8;
  localparam int ATTR_W = 3;

  typedef struct packed {
    logic [PFN_W-1:0]  frame;
    logic [ATTR_W-1:0] attr;
    logic              dirty;
    logic              valid;
  } page_rec_t;

  typedef struct packed {
    logic [VPN_W-1:0]  tag;
    logic [VPN_W-1:0]  mask;
    logic [ASID_W-1:0] asid;
    logic              glob;
    page_rec_t         even;
    page_rec_t         odd;
  } tlb_entry_t;

  localparam int ENT_W = $bits(tlb_entry_t);
endpackage

// File: rtl/tlb_match_cell.sv
module tlb_match_cell
  import tlb_pkg::*;
(
  input  tlb_entry_t        ent,
  input  logic [VPN_W-1:0]  vpn,
  input  logic [ASID_W-1:0] asid,
  output logic              match
);
  logic live, tag_ok, id_ok;

  always_comb begin
    live   = ent.even.valid | ent.odd.valid;
    tag_ok = ((vpn ^ ent.tag) & ~ent.mask) == '0;
    id_ok  = ent.glob | (ent.asid == asid);
    match  = live & tag_ok & id_ok;
  end
endmodule

// File: rtl/tlb_lowest_pick.sv
module tlb_lowest_pick #(
  parameter int DEPTH = 16,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic [DEPTH-1:0] req,
  output logic             any,
  output logic [IDX_W-1:0] idx
);
  always_comb begin
    idx = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (req[i]) idx = IDX_W'(i);
    end
    any = |req;
  end
endmodule

// File: rtl/tlb_entry_store.sv
module tlb_entry_store
  import tlb_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   flush,
  input  logic                   wr_en,
  input  logic [IDX_W:0]         wr_idx,
  input  tlb_entry_t             wr_data,
  input  logic                   ptr_adv,
  output tlb_entry_t [DEPTH-1:0] ent_q,
  output logic [IDX_W-1:0]       ptr_q
);
  localparam logic [IDX_W:0]   LIMIT = (IDX_W+1)'(DEPTH);
  localparam logic [IDX_W-1:0] LAST  = IDX_W'(DEPTH - 1);

  logic in_range;
  assign in_range = wr_idx < LIMIT;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ent_q <= '0;
      ptr_q <= '0;
    end else if (flush) begin
      ent_q <= '0;
      ptr_q <= '0;
    end else begin
      if (wr_en && in_range) ent_q[wr_idx[IDX_W-1:0]] <= wr_data;
      if (ptr_adv) ptr_q <= (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
    end
  end

  assert_oob_write_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !in_range && !flush) |=> $stable(ent_q));

  assert_flush_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (ptr_q == '0 && ent_q == '0));

  assert_ptr_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!flush && !ptr_adv) |=> $stable(ptr_q));
endmodule

// File: rtl/paired_tlb.sv
module paired_tlb
  import tlb_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  lk_valid,
  input  logic [VPN_W-1:0]      lk_vpn,
  input  logic [ASID_W-1:0]     lk_asid,
  output logic                  hit,
  output logic [IDX_W-1:0]      hit_idx,
  output logic [IDX_W:0]        probe_res,
  output logic [ENT_W-1:0]      hit_data,
  input  logic                  wr_en,
  input  logic [IDX_W:0]        wr_idx,
  input  logic [ENT_W-1:0]      wr_data,
  input  logic                  flush,
  input  logic                  ptr_adv,
  output logic [IDX_W-1:0]      ptr,
  output logic [ENT_W-1:0]      ptr_data
);
  tlb_entry_t [DEPTH-1:0] ent_q;
  logic [DEPTH-1:0]       match_vec;
  logic                   any_match;

  tlb_entry_store #(.DEPTH(DEPTH)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .flush   (flush),
    .wr_en   (wr_en),
    .wr_idx  (wr_idx),
    .wr_data (tlb_entry_t'(wr_data)),
    .ptr_adv (ptr_adv),
    .ent_q   (ent_q),
    .ptr_q   (ptr)
  );

  for (genvar g = 0; g < DEPTH; g++) begin : g_cell
    tlb_match_cell u_cell (
      .ent   (ent_q[g]),
      .vpn   (lk_vpn),
      .asid  (lk_asid),
      .match (match_vec[g])
    );
  end

  tlb_lowest_pick #(.DEPTH(DEPTH)) u_pick (
    .req (match_vec),
    .any (any_match),
    .idx (hit_idx)
  );

  always_comb begin
    hit       = lk_valid & any_match;
    probe_res = hit ? {1'b0, hit_idx} : '1;
    hit_data  = hit ? ENT_W'(ent_q[hit_idx]) : '0;
    ptr_data  = ENT_W'(ent_q[ptr]);
  end

  assert_hit_is_match_R4: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> match_vec[hit_idx]);

  assert_lowest_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> ((match_vec & ((DEPTH'(1) << hit_idx) - DEPTH'(1))) == '0));

  assert_probe_code_R5: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> (probe_res[IDX_W] == 1'b0 && probe_res[IDX_W-1:0] == hit_idx));

  assert_idle_no_hit_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |-> (!hit && &probe_res));
endmodule

// File: tb/test_paired_tlb.sv
`timescale 1ns/1ps
module test_paired_tlb;
  import tlb_pkg::*;
  localparam int DEPTH = 16;
  localparam int IDX_W = 4;

  logic clk = 0, rst_n = 0;
  logic lk_valid = 0;
  logic [VPN_W-1:0] lk_vpn = '0;
  logic [ASID_W-1:0] lk_asid = '0;
  logic hit;
  logic [IDX_W-1:0] hit_idx;
  logic [IDX_W:0] probe_res;
  logic [ENT_W-1:0] hit_data, ptr_data;
  logic wr_en = 0, flush = 0, ptr_adv = 0;
  logic [IDX_W:0] wr_idx = '0;
  logic [ENT_W-1:0] wr_data = '0;
  logic [IDX_W-1:0] ptr;

  int n_chk = 0, n_bad = 0;

  always #10 clk = ~clk;

  paired_tlb #(.DEPTH(DEPTH)) i_paired_tlb (
    .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_vpn(lk_vpn), .lk_asid(lk_asid),
    .hit(hit), .hit_idx(hit_idx), .probe_res(probe_res), .hit_data(hit_data),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data), .flush(flush),
    .ptr_adv(ptr_adv), .ptr(ptr), .ptr_data(ptr_data)
  );

  function automatic tlb_entry_t mk(logic [VPN_W-1:0] tag, logic [VPN_W-1:0] mask,
                                    logic [ASID_W-1:0] asid, logic glob,
                                    logic ve, logic vo);
    tlb_entry_t e;
    e.tag = tag; e.mask = mask; e.asid = asid; e.glob = glob;
    e.even = '{frame: 20'h0A000 + PFN_W'(tag), attr: 3'd3, dirty: 1'b1, valid: ve};
    e.odd  = '{frame: 20'h0B000 + PFN_W'(tag), attr: 3'd2, dirty: 1'b0, valid: vo};
    return e;
  endfunction

  task automatic chk(string req, logic [127:0] act, logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [IDX_W:0] idx, tlb_entry_t e);
    @(negedge clk);
    wr_en = 1; wr_idx = idx; wr_data = ENT_W'(e);
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic look(logic v, logic [VPN_W-1:0] vpn, logic [ASID_W-1:0] asid);
    @(negedge clk);
    lk_valid = v; lk_vpn = vpn; lk_asid = asid;
    #1;
  endtask

  // vector: {vpn, asid, exp_hit, exp_idx}
  localparam int VW = VPN_W + ASID_W + 1 + IDX_W;
  localparam logic [VW-1:0] VEC [8] = '{
    {19'h00100, 8'd5,   1'b1, 4'd0},  // R2 asid equal
    {19'h00100, 8'd7,   1'b1, 4'd2},  // R2 other asid, other entry
    {19'h00100, 8'd6,   1'b0, 4'd0},  // R2 asid mismatch
    {19'h0020A, 8'd33,  1'b1, 4'd1},  // R1 masked bits differ, global
    {19'h0021A, 8'd0,   1'b0, 4'd0},  // R1 unmasked bit differs
    {19'h00300, 8'd9,   1'b0, 4'd0},  // R3 both valid bits clear
    {19'h00200, 8'hFF,  1'b1, 4'd1},  // R2 global overrides asid
    {19'h00101, 8'd5,   1'b0, 4'd0}   // R1 exact tag bit differs
  };

  initial begin
    #2000000;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    tlb_entry_t e0, e1, e2, e3, e5, e0b, eo;
    e0 = mk(19'h00100, 19'h0, 8'd5, 1'b0, 1'b1, 1'b0);
    e1 = mk(19'h00200, 19'h0000F, 8'd0, 1'b1, 1'b0, 1'b1);
    e2 = mk(19'h00100, 19'h0, 8'd7, 1'b0, 1'b1, 1'b1);
    e3 = mk(19'h00300, 19'h0, 8'd9, 1'b0, 1'b0, 1'b0);
    e5 = mk(19'h00100, 19'h0, 8'd5, 1'b0, 1'b1, 1'b1);
    e0b = mk(19'h00100, 19'h0, 8'd6, 1'b0, 1'b1, 1'b0);
    eo = mk(19'h00400, 19'h0, 8'd1, 1'b1, 1'b1, 1'b1);

    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    // R11 reset state
    chk("R11 ptr", 128'(ptr), 128'(0));
    chk("R11 ptr_data", 128'(ptr_data), 128'(0));
    look(1'b1, 19'h0, 8'h0);
    chk("R3 zeroed entry no hit", 128'(hit), 128'(0));
    chk("R5 miss code", 128'(probe_res), 128'(5'h1F));

    wr(5'd0, e0); wr(5'd1, e1); wr(5'd2, e2); wr(5'd3, e3); wr(5'd5, e5);
    // R8 effect visible right after the writing edge
    chk("R8 readback entry 0", 128'(ptr_data), 128'(ENT_W'(e0)));

    for (int k = 0; k < 8; k++) begin
      logic [VW-1:0] v;
      v = VEC[k];
      look(1'b1, v[VW-1 -: VPN_W], v[IDX_W+ASID_W : IDX_W+1]);
      chk("R1/R2/R3 hit", 128'(hit), 128'(v[IDX_W]));
      chk("R5 probe", 128'(probe_res), v[IDX_W] ? 128'({1'b0, v[IDX_W-1:0]}) : 128'(5'h1F));
    end

    look(1'b1, 19'h00100, 8'd7);
    chk("R6 hit_data", 128'(hit_data), 128'(ENT_W'(e2)));
    look(1'b1, 19'h00100, 8'd6);
    chk("R6 miss data zero", 128'(hit_data), 128'(0));

    // R4 duplicate at 0 and 5: lowest wins, then moves to 5
    look(1'b1, 19'h00100, 8'd5);
    chk("R4 lowest index", 128'(hit_idx), 128'(0));
    wr(5'd0, e0b);
    look(1'b1, 19'h00100, 8'd5);
    chk("R4 next match after rewrite", 128'(probe_res), 128'(5'd5));

    // R12 idle request
    look(1'b0, 19'h00100, 8'd5);
    chk("R12 no hit when idle", 128'(hit), 128'(0));
    chk("R12 probe all ones", 128'(probe_res), 128'(5'h1F));

    // R7 out-of-range write
    wr(5'd16, eo);
    look(1'b1, 19'h00400, 8'd1);
    chk("R7 oob write no hit", 128'(hit), 128'(0));
    chk("R7 entry 0 intact", 128'(ptr_data), 128'(ENT_W'(e0b)));

    // R10 pointer
    @(negedge clk); ptr_adv = 1;
    @(negedge clk); ptr_adv = 0;
    chk("R10 ptr step", 128'(ptr), 128'(1));
    chk("R10 ptr_data", 128'(ptr_data), 128'(ENT_W'(e1)));
    repeat (2) @(negedge clk);
    chk("R10 ptr holds", 128'(ptr), 128'(1));
    @(negedge clk); ptr_adv = 1;
    repeat (16) @(negedge clk);
    ptr_adv = 0;
    chk("R10 wrap", 128'(ptr), 128'(1));

    // R9 flush with competing write and advance
    @(negedge clk); flush = 1; ptr_adv = 1; wr_en = 1; wr_idx = 5'd4; wr_data = ENT_W'(eo);
    @(negedge clk); flush = 0; ptr_adv = 0; wr_en = 0;
    chk("R9 ptr zero", 128'(ptr), 128'(0));
    chk("R9 entry 0 cleared", 128'(ptr_data), 128'(0));
    look(1'b1, 19'h00400, 8'd1);
    chk("R9 flush beats write", 128'(hit), 128'(0));
    look(1'b1, 19'h00100, 8'd7);
    chk("R9 flushed no hit", 128'(hit), 128'(0));

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule